// File: doc/BRIEF.md
# In-Place Tree Sum Reducer

This block adds up a fixed-size array of unsigned words using a halving-stride tree. A start pulse captures all input words into an internal register array. From then on, each clock performs one round of additions in parallel. In a round with stride S, every lane j below S adds lane j+S into itself. The stride begins at half the lane count and halves after each round. After log2(LANES) rounds, lane 0 holds the total.

Lanes that a round does not write keep their contents. The finished array therefore shows every intermediate partial sum, which is useful for inspection or for reuse by a neighbouring block. Exactly LANES-1 additions take place over a whole reduction, and no result is ever thrown away. A one-cycle done pulse marks completion. The total and the array then hold still until the next accepted start.

Top module: `tree_sum_reducer`

## Requirements
- R1: While and after synchronous reset, busy and done are 0 and every array word reads 0.
- R2: A start sampled high while busy is 0 copies din into the array at that clock edge, and busy reads 1 in the following cycle. Word i of din is bits [i*WIDTH +: WIDTH], and word i of arr uses the same bit positions.
- R3: One round runs per clock. The stride takes the values LANES/2, LANES/4, down to 1. busy stays high for exactly log2(LANES) cycles. done is high in the cycle after the edge that performs the last round.
- R4: In a round with stride S, each lane j < S becomes old[j] + old[j+S], and every other lane keeps its value. For inputs 1..8, the array is 6,8,10,12,5,6,7,8 after round 1 and 16,20,10,12,5,6,7,8 after round 2.
- R5: When done is high, total equals array word 0, which is the sum of all inputs. For inputs 1..8, the final array is 36,20,10,12,5,6,7,8.
- R6: All additions wrap modulo 2^WIDTH.
- R7: A start that arrives while busy is 1 is ignored. The running reduction keeps its timing and its results.
- R8: done is a one-cycle pulse. The array and total stay unchanged while busy is 0 and no start arrives.
- R9: The same behaviour holds for any power-of-two LANES of at least 2, including 2, 8 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load and begin a reduction, honoured only while idle |
| din | input | LANES*WIDTH | Input words, word i at [i*WIDTH +: WIDTH] |
| busy | output | 1 | Reduction rounds in progress |
| done | output | 1 | One-cycle pulse after the final round |
| total | output | WIDTH | Array word 0 |
| arr | output | LANES*WIDTH | Whole working array, same layout as din |

## Verification
On every cycle, the assertions check four things. The done pulse lasts one cycle. The stride holds a single set bit while busy. The last round is followed by done with busy low. An ignored start still lets the stride halve. They also check that every lane outside the active range, and the whole array while idle, holds its value. Only the bench scenarios can show the arithmetic itself. That covers the exact partial sums after each round, the wrap of the total, and the agreement with a software model for random data at 2, 8 and 16 lanes.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;
endpackage

// File: rtl/tsr_sequencer.sv
module tsr_sequencer
  import tsr_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  output logic                       load,
  output logic                       step,
  output logic [$clog2(LANES):0]     stride,
  output logic                       busy,
  output logic                       done
);
  localparam int SW = $clog2(LANES) + 1;

  run_state_t state;
  logic       last;

  assign load = start && (state == ST_IDLE);
  assign step = (state == ST_RUN);
  assign busy = (state == ST_RUN);
  assign last = (stride == SW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      stride <= '0;
      done   <= 1'b0;
    end else begin
      done <= step && last;
      if (load) begin
        state  <= ST_RUN;
        stride <= SW'(LANES / 2);
      end else if (step) begin
        stride <= stride >> 1;
        if (last) state <= ST_IDLE;
      end
    end
  end

  AST_STRIDE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(stride) == 1));  // R3
  AST_LAST_ROUND_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy && last) |=> (done && !busy));  // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (stride == ($past(stride) >> 1)));  // R7
endmodule

// File: rtl/tsr_lane_bank.sv
module tsr_lane_bank #(
  parameter int LANES = 8,
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   step,
  input  logic [$clog2(LANES):0] stride,
  input  logic [LANES*WIDTH-1:0] din,
  output logic [LANES*WIDTH-1:0] arr
);
  localparam int LVLS = $clog2(LANES);
  localparam int SW   = LVLS + 1;
  localparam int HALF = LANES / 2;

  logic [WIDTH-1:0] mem [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign arr[j*WIDTH +: WIDTH] = mem[j];

    if (j < HALF) begin : g_adder
      logic [WIDTH-1:0] cand [LVLS];
      logic [WIDTH-1:0] partner;
      logic             active;

      for (genvar k = 0; k < LVLS; k++) begin : g_cand
        if (j < (1 << k)) begin : g_on
          assign cand[k] = mem[j + (1 << k)];
        end else begin : g_off
          assign cand[k] = '0;
        end
      end

      always_comb begin
        partner = '0;
        for (int k = 0; k < LVLS; k++) begin
          if (stride == SW'(1 << k)) partner = cand[k];
        end
      end

      assign active = step && (stride > SW'(j));

      always_ff @(posedge clk) begin
        if (rst)         mem[j] <= '0;
        else if (load)   mem[j] <= din[j*WIDTH +: WIDTH];
        else if (active) mem[j] <= mem[j] + partner;
      end

      AST_LOW_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !active) |=> $stable(mem[j]));  // R4
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)       mem[j] <= '0;
        else if (load) mem[j] <= din[j*WIDTH +: WIDTH];
      end

      AST_HIGH_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mem[j]));  // R4
    end
  end
endmodule

// File: rtl/tree_sum_reducer.sv
module tree_sum_reducer #(
  parameter int LANES = 8,
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [LANES*WIDTH-1:0] din,
  output logic                   busy,
  output logic                   done,
  output logic [WIDTH-1:0]       total,
  output logic [LANES*WIDTH-1:0] arr
);
  localparam int SW = $clog2(LANES) + 1;

  logic          load;
  logic          step;
  logic [SW-1:0] stride;

  tsr_sequencer #(.LANES(LANES)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .load   (load),
    .step   (step),
    .stride (stride),
    .busy   (busy),
    .done   (done)
  );

  tsr_lane_bank #(.LANES(LANES), .WIDTH(WIDTH)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .stride (stride),
    .din    (din),
    .arr    (arr)
  );

  assign total = arr[WIDTH-1:0];

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(arr));  // R8
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);  // R2
endmodule

// File: tb/tree_sum_reducer_bench.sv
module tree_sum_reducer_bench;
  localparam int W    = 16;
  localparam int MAXN = 16;
  typedef logic [W-1:0] vec_t [MAXN];
  typedef logic [MAXN*W-1:0] flat_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst;

  logic st8, st2, st16;
  logic [8*W-1:0]  d8;
  logic [2*W-1:0]  d2;
  logic [16*W-1:0] d16;
  logic b8, b2, b16, dn8, dn2, dn16;
  logic [W-1:0] t8, t2, t16;
  logic [8*W-1:0]  a8;
  logic [2*W-1:0]  a2;
  logic [16*W-1:0] a16;

  tree_sum_reducer #(.LANES(8), .WIDTH(W)) u_tree_sum_reducer (
    .clk(clk), .rst(rst), .start(st8), .din(d8),
    .busy(b8), .done(dn8), .total(t8), .arr(a8));
  tree_sum_reducer #(.LANES(2), .WIDTH(W)) u_tree_sum_reducer_n2 (
    .clk(clk), .rst(rst), .start(st2), .din(d2),
    .busy(b2), .done(dn2), .total(t2), .arr(a2));
  tree_sum_reducer #(.LANES(16), .WIDTH(W)) u_tree_sum_reducer_n16 (
    .clk(clk), .rst(rst), .start(st16), .din(d16),
    .busy(b16), .done(dn16), .total(t16), .arr(a16));

  int total_chk = 0;
  int bad = 0;

  task automatic check(string tag, flat_t act, flat_t exp);
    total_chk++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic flat_t pack(vec_t v, int n);
    flat_t r = '0;
    for (int i = 0; i < n; i++) r[i*W +: W] = v[i];
    return r;
  endfunction

  function automatic flat_t get_arr(int id);
    flat_t r = '0;
    case (id)
      0: r[8*W-1:0]  = a8;
      1: r[2*W-1:0]  = a2;
      default: r     = a16;
    endcase
    return r;
  endfunction

  function automatic logic get_busy(int id);
    return (id == 0) ? b8 : (id == 1) ? b2 : b16;
  endfunction

  function automatic logic get_done(int id);
    return (id == 0) ? dn8 : (id == 1) ? dn2 : dn16;
  endfunction

  function automatic logic [W-1:0] get_total(int id);
    return (id == 0) ? t8 : (id == 1) ? t2 : t16;
  endfunction

  task automatic drive(int id, logic s, vec_t v);
    case (id)
      0: begin st8 = s;  for (int i = 0; i < 8; i++)  d8[i*W +: W]  = v[i]; end
      1: begin st2 = s;  for (int i = 0; i < 2; i++)  d2[i*W +: W]  = v[i]; end
      default: begin st16 = s; for (int i = 0; i < 16; i++) d16[i*W +: W] = v[i]; end
    endcase
  endtask

  // Full reduction with per-round comparison against a software model.
  task automatic run_check(int id, int n, vec_t v, string tag, bit inject);
    vec_t m = v;
    vec_t alt;
    flat_t held;
    int lg = $clog2(n);
    for (int i = 0; i < MAXN; i++) alt[i] = W'(16'h0BAD + i);
    @(negedge clk);
    drive(id, 1'b1, v);
    @(negedge clk);
    drive(id, 1'b0, v);
    check({tag, " R2 load"}, get_arr(id), pack(m, n));
    check({tag, " R2 busy"}, flat_t'(get_busy(id)), flat_t'(1));
    for (int s = 1; s <= lg; s++) begin
      int str = n >> s;
      if (inject && s == 1) drive(id, 1'b1, alt);
      @(negedge clk);
      if (inject && s == 1) drive(id, 1'b0, alt);
      for (int j = 0; j < str; j++) m[j] = m[j] + m[j + str];
      check($sformatf("%s R4 round %0d", tag, s), get_arr(id), pack(m, n));
      check($sformatf("%s R3 done round %0d", tag, s),
            flat_t'(get_done(id)), flat_t'(s == lg));
      check($sformatf("%s R3 busy round %0d", tag, s),
            flat_t'(get_busy(id)), flat_t'(s != lg));
    end
    check({tag, " R5 total"}, flat_t'(get_total(id)), flat_t'(m[0]));
    held = get_arr(id);
    @(negedge clk);
    check({tag, " R8 done pulse"}, flat_t'(get_done(id)), flat_t'(0));
    repeat (3) @(negedge clk);
    check({tag, " R8 hold"}, get_arr(id), held);
  endtask

  task automatic t_reset();
    vec_t z;
    for (int i = 0; i < MAXN; i++) z[i] = '0;
    rst = 1'b1;
    drive(0, 1'b0, z); drive(1, 1'b0, z); drive(2, 1'b0, z);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int id = 0; id < 3; id++) begin
      check("R1 arr", get_arr(id), '0);
      check("R1 busy", flat_t'(get_busy(id)), '0);
      check("R1 done", flat_t'(get_done(id)), '0);
    end
  endtask

  task automatic t_known();
    vec_t v;
    vec_t f;
    for (int i = 0; i < MAXN; i++) begin v[i] = W'(i + 1); f[i] = '0; end
    run_check(0, 8, v, "known", 1'b0);
    f[0] = 36; f[1] = 20; f[2] = 10; f[3] = 12;
    f[4] = 5;  f[5] = 6;  f[6] = 7;  f[7] = 8;
    check("known R5 final array", get_arr(0), pack(f, 8));
  endtask

  task automatic t_wrap();
    vec_t v;
    for (int i = 0; i < MAXN; i++) v[i] = 16'hFFFF;
    run_check(0, 8, v, "wrap R6", 1'b0);
    check("wrap R6 total", flat_t'(t8), flat_t'(16'hFFF8));
  endtask

  task automatic t_ignore();
    vec_t v;
    for (int i = 0; i < MAXN; i++) v[i] = W'(3 * i + 2);
    run_check(0, 8, v, "ignore R7", 1'b1);
  endtask

  task automatic t_random();
    vec_t v;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < MAXN; i++) v[i] = W'($urandom);
      run_check(1, 2, v, "rand n2 R9", 1'b0);
      for (int i = 0; i < MAXN; i++) v[i] = W'($urandom);
      run_check(0, 8, v, "rand n8 R9", 1'b0);
      for (int i = 0; i < MAXN; i++) v[i] = W'($urandom);
      run_check(2, 16, v, "rand n16 R9", 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total_chk, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_known();
    t_wrap();
    t_ignore();
    t_random();
    $display("  test done: total=%0d bad=%0d", total_chk, bad);
    $finish;
  end
endmodule